// File: doc/BRIEF.md
# Electron/Photon Seed Finder for a 3x3 Calorimeter Tower Window

This block looks at one window of nine calorimeter trigger towers, arranged three by three around a centre tower. Each tower brings an electromagnetic and a hadronic transverse energy on an 8-bit scale. The block decides whether the centre tower seeds an electron or photon candidate. It reports the candidate energy, a valid flag, an isolation flag, and the position of the tower that pairs with the centre. Each tower spans one 0.087 by 0.087 cell in eta-phi, so the position has single-tower resolution.

The candidate energy is the centre's electromagnetic energy plus that of its strongest edge neighbour. This covers both the horizontal and the vertical two-tower shapes. A hadronic-fraction veto is tested in all nine towers. Isolation is judged from which of the eight surrounding towers are quiet, using electromagnetic plus hadronic energy. A larger system scans this window over the tower array. Sorting and track matching happen downstream.

Tower i sits at row i/3 and column i%3, with tower 4 at the centre. Tower i is carried on bits [8*i+7 : 8*i] of each flat input bus.

Top module: `egamma_seed_finder`

## Requirements
- R1: Outputs are registered. A window presented with `in_valid` high at one rising edge appears on the outputs after that edge. After reset, `cand_et`, `cand_valid`, `cand_iso` and `pair_dir` are all zero.
- R2: `cand_et` is the centre electromagnetic energy plus the largest electromagnetic energy among the edge neighbours 1, 3, 5 and 7. The sum saturates at 255 and does not wrap.
- R3: `pair_dir` names the chosen neighbour: 0 for tower 1 (above), 1 for tower 3 (left), 2 for tower 5 (right), 3 for tower 7 (below). On equal energies the lower tower index wins.
- R4: The centre is a seed only if its electromagnetic energy is strictly greater than that of towers 0 to 3 and greater than or equal to that of towers 5 to 8.
- R5: A tower passes the hadronic cut when its hadronic energy shifted left by `HOE_SHIFT` (default 3, so times 8) does not exceed its electromagnetic energy. `cand_valid` requires all nine towers to pass.
- R6: A tower is quiet when its electromagnetic plus hadronic energy (9 bits) is strictly below `quiet_thr`.
- R7: `cand_iso` is high when every tower of at least one side group is quiet. The side groups are: above {0,1,2,3,5}, below {3,5,6,7,8}, left {0,1,3,6,7}, right {1,2,5,7,8}. The centre never counts.
- R8: In a cycle with `in_valid` low, `cand_valid` goes low on the next edge and `cand_et`, `cand_iso` and `pair_dir` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window present; enables the output registers |
| em_flat | input | 72 | Electromagnetic energy of nine towers, tower i at bits 8i+7:8i |
| had_flat | input | 72 | Hadronic energy of nine towers, same packing |
| quiet_thr | input | 9 | Combined-energy limit below which a tower is quiet |
| cand_et | output | 8 | Saturated two-tower candidate energy |
| cand_valid | output | 1 | Centre is a seed and the hadronic cut passes in all nine towers |
| cand_iso | output | 1 | At least one side group is entirely quiet |
| pair_dir | output | 2 | Neighbour paired with the centre (0 above, 1 left, 2 right, 3 below) |

## Verification
The stimulus starts with a window whose four edge neighbours all differ. This shows that the partner is the strongest one and not a fixed direction. A large centre next to a large neighbour separates saturation from wrap-around. Equal-energy windows are placed in a neighbour pair and in a corner on both sides of the centre. These show the lower-index tie rule in both partner choice and seeding. Single hot towers are placed to make exactly one side group quiet and then none. Energies are split between the two calorimeter layers to sit exactly on the hadronic-cut boundary and exactly on the quiet threshold.

// File: rtl/egc_pkg.sv
package egc_pkg;
  localparam int NTOW   = 9;
  localparam int CENTRE = 4;

  typedef enum logic [1:0] {
    DIR_UP    = 2'd0,
    DIR_LEFT  = 2'd1,
    DIR_RIGHT = 2'd2,
    DIR_DOWN  = 2'd3
  } pair_dir_e;

  // Side groups of surrounding towers (bit i = tower i)
  localparam logic [NTOW-1:0] SIDE_UP    = 9'h02F;
  localparam logic [NTOW-1:0] SIDE_DOWN  = 9'h1E8;
  localparam logic [NTOW-1:0] SIDE_LEFT  = 9'h0CB;
  localparam logic [NTOW-1:0] SIDE_RIGHT = 9'h1A6;
endpackage

// File: rtl/egc_tower_cut.sv
module egc_tower_cut #(
  parameter int ET_W      = 8,
  parameter int HOE_SHIFT = 3
) (
  input  logic [ET_W-1:0] em_i,
  input  logic [ET_W-1:0] had_i,
  input  logic [ET_W:0]   thr_i,
  output logic            hoe_ok_o,
  output logic            quiet_o
);
  localparam int SH_W = ET_W + HOE_SHIFT;

  logic [SH_W-1:0] had_scaled;
  logic [ET_W:0]   combined;

  always_comb begin
    had_scaled = SH_W'(had_i) << HOE_SHIFT;
    hoe_ok_o   = had_scaled <= SH_W'(em_i);
    combined   = {1'b0, em_i} + {1'b0, had_i};
    quiet_o    = combined < thr_i;
  end
endmodule

// File: rtl/egc_pair_select.sv
module egc_pair_select
  import egc_pkg::*;
#(
  parameter int ET_W = 8
) (
  input  logic [NTOW*ET_W-1:0] em_flat_i,
  output logic [ET_W-1:0]      sum_o,
  output logic [ET_W-1:0]      partner_em_o,
  output pair_dir_e            dir_o
);
  logic [ET_W-1:0] best;
  logic [1:0]      best_k;
  logic [ET_W-1:0] cand;
  logic [ET_W:0]   raw_sum;

  always_comb begin
    best   = em_flat_i[1*ET_W +: ET_W];
    best_k = 2'd0;
    for (int k = 1; k < 4; k++) begin
      cand = em_flat_i[(2*k+1)*ET_W +: ET_W];
      if (cand > best) begin
        best   = cand;
        best_k = 2'(k);
      end
    end
    raw_sum      = {1'b0, em_flat_i[CENTRE*ET_W +: ET_W]} + {1'b0, best};
    sum_o        = raw_sum[ET_W] ? {ET_W{1'b1}} : raw_sum[ET_W-1:0];
    partner_em_o = best;
    dir_o        = pair_dir_e'(best_k);
  end
endmodule

// File: rtl/egc_seed_check.sv
module egc_seed_check
  import egc_pkg::*;
#(
  parameter int ET_W = 8
) (
  input  logic [NTOW*ET_W-1:0] em_flat_i,
  output logic                 seed_o
);
  logic [ET_W-1:0] centre;

  always_comb begin
    centre = em_flat_i[CENTRE*ET_W +: ET_W];
    seed_o = 1'b1;
    for (int i = 0; i < NTOW; i++) begin
      if (i < CENTRE) begin
        if (!(centre > em_flat_i[i*ET_W +: ET_W])) seed_o = 1'b0;
      end else if (i > CENTRE) begin
        if (!(centre >= em_flat_i[i*ET_W +: ET_W])) seed_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/egamma_seed_finder.sv
module egamma_seed_finder
  import egc_pkg::*;
#(
  parameter int ET_W      = 8,
  parameter int HOE_SHIFT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [NTOW*ET_W-1:0] em_flat,
  input  logic [NTOW*ET_W-1:0] had_flat,
  input  logic [ET_W:0]        quiet_thr,
  output logic [ET_W-1:0]      cand_et,
  output logic                 cand_valid,
  output logic                 cand_iso,
  output logic [1:0]           pair_dir
);
  logic [NTOW-1:0] hoe_vec;
  logic [NTOW-1:0] quiet_vec;
  logic [ET_W-1:0] pair_sum;
  logic [ET_W-1:0] partner_em;
  pair_dir_e       pair_sel;
  logic            seed;
  logic            iso_now;

  logic [ET_W-1:0] et_d;
  logic            valid_d;
  logic            iso_d;
  logic [1:0]      dir_d;

  for (genvar g = 0; g < NTOW; g++) begin : g_tower
    egc_tower_cut #(.ET_W(ET_W), .HOE_SHIFT(HOE_SHIFT)) u_cut (
      .em_i     (em_flat[g*ET_W +: ET_W]),
      .had_i    (had_flat[g*ET_W +: ET_W]),
      .thr_i    (quiet_thr),
      .hoe_ok_o (hoe_vec[g]),
      .quiet_o  (quiet_vec[g])
    );
  end

  egc_pair_select #(.ET_W(ET_W)) u_pair (
    .em_flat_i    (em_flat),
    .sum_o        (pair_sum),
    .partner_em_o (partner_em),
    .dir_o        (pair_sel)
  );

  egc_seed_check #(.ET_W(ET_W)) u_seed (
    .em_flat_i (em_flat),
    .seed_o    (seed)
  );

  always_comb begin
    iso_now = ((quiet_vec & SIDE_UP)    == SIDE_UP)   ||
              ((quiet_vec & SIDE_DOWN)  == SIDE_DOWN) ||
              ((quiet_vec & SIDE_LEFT)  == SIDE_LEFT) ||
              ((quiet_vec & SIDE_RIGHT) == SIDE_RIGHT);
  end

  // next state
  always_comb begin
    et_d    = cand_et;
    iso_d   = cand_iso;
    dir_d   = pair_dir;
    valid_d = 1'b0;
    if (in_valid) begin
      et_d    = pair_sum;
      iso_d   = iso_now;
      dir_d   = pair_sel;
      valid_d = seed && (&hoe_vec);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_et    <= '0;
      cand_valid <= 1'b0;
      cand_iso   <= 1'b0;
      pair_dir   <= '0;
    end else begin
      cand_et    <= et_d;
      cand_valid <= valid_d;
      cand_iso   <= iso_d;
      pair_dir   <= dir_d;
    end
  end

  // assertions
  assert_valid_follows_input_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> $past(in_valid));

  assert_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> cand_et >= $past(em_flat[CENTRE*ET_W +: ET_W]));

  assert_partner_strongest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (partner_em >= em_flat[1*ET_W +: ET_W]) &&
                 (partner_em >= em_flat[3*ET_W +: ET_W]) &&
                 (partner_em >= em_flat[5*ET_W +: ET_W]) &&
                 (partner_em >= em_flat[7*ET_W +: ET_W]));

  assert_seed_centre_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && seed) |-> em_flat[CENTRE*ET_W +: ET_W] >= partner_em);

  assert_valid_needs_hoe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> $past(&hoe_vec));

  assert_iso_needs_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!cand_iso || $countones($past(quiet_vec)) >= 5));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!cand_valid && $stable(cand_et) && $stable(pair_dir) && $stable(cand_iso)));
endmodule

// File: tb/egamma_seed_finder_bench.sv
module egamma_seed_finder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [71:0] em_flat;
  logic [71:0] had_flat;
  logic [8:0]  quiet_thr;
  logic [7:0]  cand_et;
  logic        cand_valid;
  logic        cand_iso;
  logic [1:0]  pair_dir;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  egamma_seed_finder u_egamma_seed_finder (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .em_flat    (em_flat),
    .had_flat   (had_flat),
    .quiet_thr  (quiet_thr),
    .cand_et    (cand_et),
    .cand_valid (cand_valid),
    .cand_iso   (cand_iso),
    .pair_dir   (pair_dir)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_win();
    em_flat  = '0;
    had_flat = '0;
  endtask

  task automatic put(int i, int em, int had);
    em_flat[i*8 +: 8]  = 8'(em);
    had_flat[i*8 +: 8] = 8'(had);
  endtask

  // present current window for one edge, sample at the following negedge
  task automatic apply();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset et", cand_et, 0);
    chk("R1 reset valid", cand_valid, 0);
    chk("R1 reset iso", cand_iso, 0);
    chk("R1 reset dir", pair_dir, 0);
  endtask

  task automatic t_strongest();
    clear_win();
    put(4, 40, 0); put(1, 10, 0); put(3, 20, 0); put(5, 30, 0); put(7, 5, 0);
    quiet_thr = 9'd32;
    apply();
    chk("R2 pair sum", cand_et, 70);
    chk("R3 dir right", pair_dir, 2);
    chk("R4 seed valid", cand_valid, 1);
    chk("R7 all sides quiet", cand_iso, 1);
    quiet_thr = 9'd16;
    apply();
    chk("R7 no side quiet", cand_iso, 0);
  endtask

  task automatic t_saturate();
    clear_win();
    put(4, 200, 0); put(7, 200, 0);
    quiet_thr = 9'd1;
    apply();
    chk("R2 saturate", cand_et, 255);
    chk("R3 dir down", pair_dir, 3);
  endtask

  task automatic t_tie();
    clear_win();
    put(4, 50, 0); put(3, 30, 0); put(5, 30, 0);
    apply();
    chk("R3 tie lower index", pair_dir, 1);
    chk("R2 tie sum", cand_et, 80);
  endtask

  task automatic t_seed_ties();
    clear_win();
    put(4, 50, 0); put(0, 50, 0);
    apply();
    chk("R4 tie low corner", cand_valid, 0);
    clear_win();
    put(4, 50, 0); put(8, 50, 0);
    apply();
    chk("R4 tie high corner", cand_valid, 1);
    clear_win();
    put(4, 50, 0); put(1, 60, 0);
    apply();
    chk("R4 hotter neighbour", cand_valid, 0);
  endtask

  task automatic t_hoe();
    clear_win();
    put(4, 50, 0); put(6, 16, 2);
    apply();
    chk("R5 hoe boundary pass", cand_valid, 1);
    put(6, 16, 3);
    apply();
    chk("R5 hoe fail corner", cand_valid, 0);
    put(6, 0, 0); put(4, 50, 7);
    apply();
    chk("R5 hoe fail centre", cand_valid, 0);
  endtask

  task automatic t_iso_sides();
    clear_win();
    quiet_thr = 9'd10;
    put(4, 100, 0); put(1, 20, 0);
    apply();
    chk("R7 only lower side quiet", cand_iso, 1);
    put(7, 20, 0);
    apply();
    chk("R7 upper and lower loud", cand_iso, 0);
    clear_win();
    put(4, 100, 0); put(1, 5, 4);
    apply();
    chk("R6 combined below thr", cand_iso, 1);
    put(0, 5, 5); put(8, 5, 5); put(3, 5, 5); put(5, 5, 5);
    apply();
    chk("R6 combined at thr loud", cand_iso, 0);
  endtask

  task automatic t_hold();
    clear_win();
    quiet_thr = 9'd32;
    put(4, 40, 0); put(5, 30, 0);
    apply();
    chk("R8 setup valid", cand_valid, 1);
    clear_win();
    put(4, 9, 0); put(1, 99, 0);
    quiet_thr = 9'd0;
    @(negedge clk);
    chk("R8 valid drops", cand_valid, 0);
    chk("R8 et held", cand_et, 70);
    chk("R8 dir held", pair_dir, 2);
    chk("R8 iso held", cand_iso, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    quiet_thr = '0;
    clear_win();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strongest();
    t_saturate();
    t_tie();
    t_seed_ties();
    t_hoe();
    t_iso_sides();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule